// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a parameterised storage register, eight bits wide by default, that changes state only on the rising clock edge. On each edge it can keep its contents, move every bit one place up, move every bit one place down, or take a whole new word in parallel. A serial input feeds the vacated bit at each end, so chains of these registers can be cascaded in either direction.

Parallel data travels over one shared bidirectional bus. Here that bus is split into an input word, an output word and a drive-enable flag. The register puts its contents on the bus only when both active-low enables are asserted and the block is not loading. In load mode the block always releases the bus, so the word to be captured can arrive on the same wires that show the contents at other times. The lowest and highest bits are also brought out on two dedicated outputs that are always driven. A synchronous active-low reset clears the register and takes priority over every mode.

Top module: `ushift_core`

## Requirements
- R1: When `rst_n` is 0 at a rising edge of `clk`, every stored bit becomes 0 after that edge, whatever `mode` and the other inputs are.
- R2: With `mode` = 2'b00 (hold) and `rst_n` = 1, the stored word is unchanged by the edge.
- R3: With `mode` = 2'b01 (up shift) and `rst_n` = 1, bit i takes the old bit i-1 for i >= 1, and bit 0 takes `ser_lo`.
- R4: With `mode` = 2'b10 (down shift) and `rst_n` = 1, bit i takes the old bit i+1 for i < WIDTH-1, and the top bit takes `ser_hi`.
- R5: With `mode` = 2'b11 (load) and `rst_n` = 1, the stored word becomes the value on `bus_in` at the edge.
- R6: `bus_oe` is 1 exactly when `oe0_n` = 0, `oe1_n` = 0 and `mode` is not 2'b11. It follows its inputs in the same cycle, with no clock edge in between.
- R7: `bus_out` always carries the stored word, with bit i of the register on bit i of the port. It is the value the bus holds whenever `bus_oe` is 1.
- R8: `end_lo` equals stored bit 0 and `end_hi` equals stored bit WIDTH-1 at all times, whatever the values of `bus_oe`, `oe0_n`, `oe1_n` and `mode`.
- R9: If `rst_n` = 0 while `mode` = 2'b11, the word on `bus_in` is ignored and the register clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low |
| mode | input | 2 | Operation select {hi,lo}: 00 hold, 01 up shift, 10 down shift, 11 load |
| oe0_n | input | 1 | First bus drive enable, active low |
| oe1_n | input | 1 | Second bus drive enable, active low |
| ser_lo | input | 1 | Serial bit that enters bit 0 on an up shift |
| ser_hi | input | 1 | Serial bit that enters the top bit on a down shift |
| bus_in | input | WIDTH | Value on the shared bus, captured in load mode |
| bus_out | output | WIDTH | Register contents offered to the shared bus |
| bus_oe | output | 1 | 1 when the register drives the shared bus |
| end_lo | output | 1 | Stored bit 0, always driven |
| end_hi | output | 1 | Stored top bit, always driven |

## Verification
Each stored result (R1 to R5, R9) appears one rising edge after the inputs that cause it. It shows on `bus_out`, `end_lo` and `end_hi` straight away, with no further register. `bus_oe` is combinational and reflects the inputs of the same cycle. The driver applies every stimulus on the falling edge and queues the expected word and enable. The monitor pops the queue 1 ns after the next rising edge, while the stimulus is still held, so it compares the new register contents and the enable that the same inputs produce.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD  = 2'b00,
      MODE_UP    = 2'b01,
      MODE_DOWN  = 2'b10,
      MODE_LOAD  = 2'b11
   } ushift_mode_e;

endpackage

// File: rtl/ushift_next.sv
module ushift_next
   import ushift_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [1:0]       mode,
   input  logic [WIDTH-1:0] cur,
   input  logic             ser_lo,
   input  logic             ser_hi,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] nxt
);

   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("ushift_next: WIDTH must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_below;
      logic from_above;

      if (i == 0) begin : g_lo_end
         assign from_below = ser_lo;
      end else begin : g_lo_mid
         assign from_below = cur[i-1];
      end

      if (i == TOP) begin : g_hi_end
         assign from_above = ser_hi;
      end else begin : g_hi_mid
         assign from_above = cur[i+1];
      end

      always_comb begin
         unique case (ushift_mode_e'(mode))
            MODE_HOLD: nxt[i] = cur[i];
            MODE_UP:   nxt[i] = from_below;
            MODE_DOWN: nxt[i] = from_above;
            MODE_LOAD: nxt[i] = load_val[i];
            default:   nxt[i] = cur[i];
         endcase
      end
   end

endmodule

// File: rtl/ushift_bus_ctl.sv
module ushift_bus_ctl
   import ushift_pkg::*;
#(
   parameter int NUM_EN = 2
) (
   input  logic [1:0]        mode,
   input  logic [NUM_EN-1:0] en_n,
   output logic              drive
);

   if (NUM_EN < 1) begin : g_bad_en
      $error("ushift_bus_ctl: NUM_EN must be at least 1");
   end

   logic all_on;
   logic loading;

   assign all_on  = ~|en_n;
   assign loading = (ushift_mode_e'(mode) == MODE_LOAD);
   assign drive   = all_on & ~loading;

endmodule

// File: rtl/ushift_core.sv
module ushift_core
   import ushift_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             oe0_n,
   input  logic             oe1_n,
   input  logic             ser_lo,
   input  logic             ser_hi,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_oe,
   output logic             end_lo,
   output logic             end_hi
);

   localparam int TOP    = WIDTH - 1;
   localparam int NUM_EN = 2;

   if (WIDTH < 2) begin : g_bad_width
      $error("ushift_core: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] state_d;

   ushift_next #(.WIDTH(WIDTH)) u_next (
      .mode     (mode),
      .cur      (state_q),
      .ser_lo   (ser_lo),
      .ser_hi   (ser_hi),
      .load_val (bus_in),
      .nxt      (state_d)
   );

   ushift_bus_ctl #(.NUM_EN(NUM_EN)) u_bus (
      .mode  (mode),
      .en_n  ({oe1_n, oe0_n}),
      .drive (bus_oe)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= state_d;
   end

   assign bus_out = state_q;
   assign end_lo  = state_q[0];
   assign end_hi  = state_q[TOP];

   // Synchronous clear wins over every mode, load included (R1, R9)
   p_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (bus_out == '0));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_HOLD) |=> $stable(bus_out));

   p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_UP) |=> (bus_out == {$past(bus_out[TOP-1:0]), $past(ser_lo)}));

   p_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DOWN) |=> (bus_out == {$past(ser_hi), $past(bus_out[TOP:1])}));

   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LOAD) |=> (bus_out == $past(bus_in)));

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LOAD) |-> !bus_oe);

   p_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (end_lo == bus_out[0]) && (end_hi == bus_out[TOP]));

endmodule

// File: tb/tb_ushift_core.sv
`timescale 1ns/1ps
module tb_ushift_core;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [1:0]   mode;
   logic         oe0_n, oe1_n, ser_lo, ser_hi;
   logic [W-1:0] bus_in;
   logic [W-1:0] bus_out;
   logic         bus_oe, end_lo, end_hi;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   ushift_core #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .oe0_n(oe0_n), .oe1_n(oe1_n),
      .ser_lo(ser_lo), .ser_hi(ser_hi), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .end_lo(end_lo), .end_hi(end_hi)
   );

   typedef struct {
      logic [W-1:0] word;
      logic         oe;
      string        tag;
   } exp_t;

   exp_t         sb[$];
   logic [W-1:0] model = '0;

   task automatic check(input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input logic r, input logic [1:0] m, input logic e0,
                       input logic e1, input logic sl, input logic sh,
                       input logic [W-1:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      rst_n = r; mode = m; oe0_n = e0; oe1_n = e1;
      ser_lo = sl; ser_hi = sh; bus_in = d;
      if (!r) model = '0;
      else begin
         case (m)
            2'b01:   model = {model[W-2:0], sl};
            2'b10:   model = {sh, model[W-1:1]};
            2'b11:   model = d;
            default: model = model;
         endcase
      end
      e.word = model;
      e.oe   = (!e0 && !e1 && (m != 2'b11));
      e.tag  = tag;
      sb.push_back(e);
   endtask

   // Monitor: compares one edge after the stimulus, while inputs still hold
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, "bus_out R7", bus_out, e.word);
         check(e.tag, "bus_oe R6", {7'b0, bus_oe}, {7'b0, e.oe});
         check(e.tag, "end_lo R8", {7'b0, end_lo}, {7'b0, e.word[0]});
         check(e.tag, "end_hi R8", {7'b0, end_hi}, {7'b0, e.word[W-1]});
      end
   end

   initial begin
      rst_n = 1'b0; mode = 2'b00; oe0_n = 1'b0; oe1_n = 1'b0;
      ser_lo = 1'b0; ser_hi = 1'b0; bus_in = '0;

      // R1: reset state
      step(0, 2'b00, 0, 0, 0, 0, 8'h00, "R1 reset");
      step(0, 2'b01, 0, 0, 1, 1, 8'hFF, "R1 reset during shift");
      // R5: load, bus released during load even with both enables low (R6)
      step(1, 2'b11, 0, 0, 0, 0, 8'hA5, "R5 load A5");
      // R2: hold, with enable combinations (R6, R8)
      step(1, 2'b00, 0, 0, 1, 1, 8'h00, "R2 hold oe on");
      step(1, 2'b00, 1, 0, 1, 1, 8'hFF, "R2 hold oe0 off");
      step(1, 2'b00, 0, 1, 0, 1, 8'h3C, "R2 hold oe1 off");
      step(1, 2'b00, 1, 1, 1, 0, 8'h3C, "R8 ends with oe off");
      // R3: up shift with both serial values
      step(1, 2'b01, 0, 0, 1, 0, 8'h00, "R3 up ser 1");
      step(1, 2'b01, 0, 0, 0, 1, 8'hFF, "R3 up ser 0");
      step(1, 2'b01, 1, 1, 1, 0, 8'h00, "R3 up oe off");
      for (int k = 0; k < 8; k++) step(1, 2'b01, 0, 0, k[0], 0, 8'h00, "R3 up walk");
      // R4: down shift with both serial values
      step(1, 2'b11, 0, 1, 0, 0, 8'h81, "R5 load 81");
      step(1, 2'b10, 0, 0, 0, 1, 8'h00, "R4 down ser 1");
      step(1, 2'b10, 0, 0, 1, 0, 8'hFF, "R4 down ser 0");
      for (int k = 0; k < 8; k++) step(1, 2'b10, 0, 1, 0, ~k[1], 8'h00, "R4 down walk");
      // R5 with various patterns, R6 release
      step(1, 2'b11, 0, 0, 1, 1, 8'h5A, "R5 load 5A");
      step(1, 2'b11, 1, 0, 0, 0, 8'hFF, "R5 load FF");
      step(1, 2'b00, 0, 0, 0, 0, 8'h00, "R2 hold after load");
      // R9: reset wins over load
      step(0, 2'b11, 0, 0, 1, 1, 8'hC3, "R9 reset over load");
      step(1, 2'b00, 0, 0, 0, 0, 8'hC3, "R9 still clear");
      step(1, 2'b11, 0, 0, 0, 0, 8'h7E, "R5 load 7E");
      step(0, 2'b10, 1, 1, 1, 1, 8'h00, "R1 reset during down");
      step(1, 2'b00, 0, 0, 0, 0, 8'h00, "R1 hold zero");
      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL R7 scoreboard: actual %0d left, expected 0", sb.size());
      end
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            #(200000 * 5);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule